// File: doc/BRIEF.md
# Crosspoint Routing Configuration Selector

This block keeps the routing state of a small digital crosspoint with four data outputs and four shared data inputs, and it drives each output together with its enable. Every output has its own 4:1 selection, so any input can feed any set of outputs and the switch never blocks. A serial control front end places a new set of per-output routing codes into a staging register. A single strobe then moves the whole staged set into the active register, so that all outputs change their routing in the same cycle.

A separate preset mode bypasses both registers. In that mode two select pins pick one of four fixed maps: broadcast from input 1, broadcast from input 2, a pairwise redundancy map, and a straight-through map. Data outputs and enables are registered. An output that is disabled drives 0, and a flag reports when the active register holds a code that is not a valid routing.

Top module: `xpt_cfg_top`

## Requirements
- R1: Each output uses a 3-bit routing code. Code 000 disables the output (enable low, data 0). Codes 001, 010, 011 and 100 connect it to input 1, 2, 3 and 4 (din bits 0 to 3). The code for output k+1 sits in stage_data bits [3k+2:3k], so output 1 uses bits 2:0.
- R2: Codes 101, 110 and 111 are never applied as a routing. An output holding such a code stays disabled. cfg_err goes high after the clock edge that loads any such code into the active register, and it stays high until a load brings in a set that is all valid.
- R3: A write to the staging register (stage_we high at a rising edge) has no effect on dout, dout_en or cfg_err until a load takes place.
- R4: When load is high at a rising edge, the staging contents from before that edge are copied into the active register. All four outputs take the new routing together on the following edge. The staged value is copied, not any word written at the same edge.
- R5: If load stays high, the copy repeats at every rising edge, so the active register follows each new staged value one edge later.
- R6: With preset_mode high, preset_sel = 00 routes input 1 to every output and preset_sel = 01 routes input 2 to every output. All enables are high. preset_sel[1] is the upper select pin.
- R7: With preset_mode high, preset_sel = 10 routes input 1 to outputs 1 and 2 and input 3 to outputs 3 and 4. preset_sel = 11 routes input n to output n.
- R8: With preset_mode low, preset_sel has no effect, and the routing comes from the active register.
- R9: A synchronous reset clears the staging register, the active register, cfg_err and all outputs. With preset_mode low, every output is then disabled.
- R10: dout and dout_en are registered. After a rising edge they reflect din and the routing as they stood just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control and data clock |
| rst | input | 1 | Synchronous active-high reset |
| stage_we | input | 1 | Write enable for the staging register |
| stage_data | input | 12 | Four 3-bit routing codes, output 1 in the low bits |
| load | input | 1 | Copy the staging register into the active register |
| preset_mode | input | 1 | Use a fixed preset map instead of the registers |
| preset_sel | input | 2 | Preset map select |
| din | input | 4 | Shared data inputs, bit 0 is input 1 |
| dout | output | 4 | Routed data outputs, bit 0 is output 1 |
| dout_en | output | 4 | Per-output drive enable |
| cfg_err | output | 1 | Active register holds an invalid code |

## Verification
Staged writes are applied with load held low while din toggles. Outputs that stay disabled show that staged data cannot leak through, and a following load shows that every output switches in the same cycle. Load is held high while the staged word changes each cycle, which separates a copy made on each edge from a copy made only once. Mixes of off codes, invalid codes and valid codes tell a disabled output apart from a mis-routed one. Each preset is tried with several din patterns so that every output's source input can be identified, and the preset select is swept with the mode off to show it is ignored. Long random runs of writes, loads, mode changes and data are compared against a cycle model.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

  typedef enum logic [1:0] {
    PRE_BCAST_A  = 2'b00,
    PRE_BCAST_B  = 2'b01,
    PRE_PAIRS    = 2'b10,
    PRE_STRAIGHT = 2'b11
  } preset_e;

  // Source input (0-based) that a preset map assigns to output k.
  function automatic int unsigned preset_src(preset_e p, int unsigned k, int unsigned n_in);
    int unsigned src;
    case (p)
      PRE_BCAST_A: src = 0;
      PRE_BCAST_B: src = 1;
      PRE_PAIRS:   src = (k / 2) * 2;
      default:     src = k;
    endcase
    return src % n_in;
  endfunction

  // A code routes when it is nonzero and names an existing input.
  function automatic logic code_routes(int unsigned code, int unsigned n_in);
    return (code != 0) && (code <= n_in);
  endfunction

  // Nonzero codes above the input count are invalid.
  function automatic logic code_bad(int unsigned code, int unsigned n_in);
    return code > n_in;
  endfunction

endpackage

// File: rtl/xpt_stage_reg.sv
module xpt_stage_reg #(
  parameter int N_OUT  = 4,
  parameter int CODE_W = 3,
  localparam int VEC_W = N_OUT * CODE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [VEC_W-1:0] wdata_i,
  output logic [VEC_W-1:0] stage_o
);

  logic [VEC_W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else if (we_i) begin
      stage_q <= wdata_i;
    end
  end

  assign stage_o = stage_q;

endmodule

// File: rtl/xpt_active_reg.sv
module xpt_active_reg
  import xpt_pkg::*;
#(
  parameter int N_OUT  = 4,
  parameter int N_IN   = 4,
  parameter int CODE_W = 3,
  localparam int VEC_W = N_OUT * CODE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [VEC_W-1:0] stage_i,
  output logic [VEC_W-1:0] act_o,
  output logic             err_o
);

  logic [VEC_W-1:0] act_q;
  logic             err_q;
  logic [N_OUT-1:0] bad;

  // Per-output invalid-code detection on the staged word.
  for (genvar k = 0; k < N_OUT; k++) begin : g_bad
    assign bad[k] = code_bad(int'(stage_i[k*CODE_W +: CODE_W]), N_IN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      err_q <= 1'b0;
    end else if (load_i) begin
      act_q <= stage_i;
      err_q <= |bad;
    end
  end

  assign act_o = act_q;
  assign err_o = err_q;

endmodule

// File: rtl/xpt_route_sel.sv
module xpt_route_sel
  import xpt_pkg::*;
#(
  parameter int N_OUT  = 4,
  parameter int N_IN   = 4,
  parameter int CODE_W = 3,
  localparam int VEC_W = N_OUT * CODE_W,
  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                   mode_i,
  input  logic [1:0]             sel_i,
  input  logic [VEC_W-1:0]       act_i,
  output logic [N_OUT*IDX_W-1:0] idx_o,
  output logic [N_OUT-1:0]       en_o
);

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    logic [CODE_W-1:0] code;
    logic [IDX_W-1:0]  reg_idx;
    logic [IDX_W-1:0]  pre_idx;
    logic              reg_en;

    assign code    = act_i[k*CODE_W +: CODE_W];
    assign reg_en  = code_routes(int'(code), N_IN);
    assign reg_idx = IDX_W'(int'(code) - 1);
    assign pre_idx = IDX_W'(preset_src(preset_e'(sel_i), k, N_IN));

    // Preset mode overrides the active register for every output.
    assign en_o[k]                  = mode_i ? 1'b1 : reg_en;
    assign idx_o[k*IDX_W +: IDX_W]  = mode_i ? pre_idx : reg_idx;
  end

endmodule

// File: rtl/xpt_out_mux.sv
module xpt_out_mux #(
  parameter int N_OUT = 4,
  parameter int N_IN  = 4,
  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_IN-1:0]        din_i,
  input  logic [N_OUT*IDX_W-1:0] idx_i,
  input  logic [N_OUT-1:0]       en_i,
  output logic [N_OUT-1:0]       dout_o,
  output logic [N_OUT-1:0]       en_o
);

  logic [N_OUT-1:0] dout_d;
  logic [N_OUT-1:0] dout_q;
  logic [N_OUT-1:0] en_q;

  for (genvar k = 0; k < N_OUT; k++) begin : g_mux
    logic [IDX_W-1:0] idx;
    assign idx       = idx_i[k*IDX_W +: IDX_W];
    assign dout_d[k] = en_i[k] & din_i[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      en_q   <= '0;
    end else begin
      dout_q <= dout_d;
      en_q   <= en_i;
    end
  end

  assign dout_o = dout_q;
  assign en_o   = en_q;

endmodule

// File: rtl/xpt_cfg_top.sv
module xpt_cfg_top #(
  parameter int N_OUT  = 4,
  parameter int N_IN   = 4,
  parameter int CODE_W = 3,
  localparam int VEC_W = N_OUT * CODE_W,
  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stage_we,
  input  logic [VEC_W-1:0] stage_data,
  input  logic             load,
  input  logic             preset_mode,
  input  logic [1:0]       preset_sel,
  input  logic [N_IN-1:0]  din,
  output logic [N_OUT-1:0] dout,
  output logic [N_OUT-1:0] dout_en,
  output logic             cfg_err
);

  logic [VEC_W-1:0]       stage_q;
  logic [VEC_W-1:0]       act_q;
  logic [N_OUT*IDX_W-1:0] route_idx;
  logic [N_OUT-1:0]       route_en;

  xpt_stage_reg #(.N_OUT(N_OUT), .CODE_W(CODE_W)) u_stage (
    .clk     (clk),
    .rst     (rst),
    .we_i    (stage_we),
    .wdata_i (stage_data),
    .stage_o (stage_q)
  );

  xpt_active_reg #(.N_OUT(N_OUT), .N_IN(N_IN), .CODE_W(CODE_W)) u_active (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .stage_i (stage_q),
    .act_o   (act_q),
    .err_o   (cfg_err)
  );

  xpt_route_sel #(.N_OUT(N_OUT), .N_IN(N_IN), .CODE_W(CODE_W)) u_route (
    .mode_i (preset_mode),
    .sel_i  (preset_sel),
    .act_i  (act_q),
    .idx_o  (route_idx),
    .en_o   (route_en)
  );

  xpt_out_mux #(.N_OUT(N_OUT), .N_IN(N_IN)) u_mux (
    .clk    (clk),
    .rst    (rst),
    .din_i  (din),
    .idx_i  (route_idx),
    .en_i   (route_en),
    .dout_o (dout),
    .en_o   (dout_en)
  );

endmodule

// File: rtl/xpt_cfg_chk.sv
module xpt_cfg_chk #(
  parameter int N_OUT  = 4,
  parameter int N_IN   = 4,
  parameter int CODE_W = 3,
  localparam int VEC_W = N_OUT * CODE_W
) (
  input logic             clk,
  input logic             rst,
  input logic             load,
  input logic             preset_mode,
  input logic [1:0]       preset_sel,
  input logic [N_IN-1:0]  din,
  input logic [N_OUT-1:0] dout,
  input logic [N_OUT-1:0] dout_en,
  input logic             cfg_err,
  input logic [VEC_W-1:0] stage_q,
  input logic [VEC_W-1:0] act_q
);

  function automatic logic any_bad(logic [VEC_W-1:0] v);
    logic b;
    b = 1'b0;
    for (int k = 0; k < N_OUT; k++) begin
      if (int'(v[k*CODE_W +: CODE_W]) > N_IN) b = 1'b1;
    end
    return b;
  endfunction

  // R9: reset leaves outputs disabled and the flag clear
  p_reset_off_r9: assert property (@(posedge clk)
    rst |=> (dout_en == '0 && !cfg_err));

  // R1: a disabled output drives 0
  p_off_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (dout & ~dout_en) == '0);

  // R3: without load the active register holds
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !load |=> act_q == $past(act_q));

  // R4: load copies the staged word
  p_copy_r4: assert property (@(posedge clk) disable iff (rst)
    load |=> act_q == $past(stage_q));

  // R2: flag follows the validity of the loaded word
  p_err_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> cfg_err == $past(any_bad(stage_q)));

  // R6: broadcast preset from input 1
  p_bcast_r6: assert property (@(posedge clk) disable iff (rst)
    (preset_mode && preset_sel == 2'b00) |=>
      (dout_en == '1 && dout == {N_OUT{$past(din[0])}}));

  // R7: straight-through preset
  p_straight_r7: assert property (@(posedge clk) disable iff (rst)
    (preset_mode && preset_sel == 2'b11) |=>
      (dout_en == '1 && dout == $past(din[N_OUT-1:0])));

endmodule

bind xpt_cfg_top xpt_cfg_chk #(.N_OUT(N_OUT), .N_IN(N_IN), .CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .load        (load),
  .preset_mode (preset_mode),
  .preset_sel  (preset_sel),
  .din         (din),
  .dout        (dout),
  .dout_en     (dout_en),
  .cfg_err     (cfg_err),
  .stage_q     (stage_q),
  .act_q       (act_q)
);

// File: tb/sim_xpt_cfg_top.sv
module sim_xpt_cfg_top;

  localparam int NO = 4;
  localparam int NI = 4;
  localparam int CW = 3;
  localparam int VW = NO * CW;

  logic          clk = 1'b0;
  logic          rst;
  logic          stage_we;
  logic [VW-1:0] stage_data;
  logic          load;
  logic          preset_mode;
  logic [1:0]    preset_sel;
  logic [NI-1:0] din;
  logic [NO-1:0] dout;
  logic [NO-1:0] dout_en;
  logic          cfg_err;

  always #10 clk = ~clk;

  xpt_cfg_top u0 (
    .clk(clk), .rst(rst), .stage_we(stage_we), .stage_data(stage_data),
    .load(load), .preset_mode(preset_mode), .preset_sel(preset_sel),
    .din(din), .dout(dout), .dout_en(dout_en), .cfg_err(cfg_err)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Cycle model state
  logic [VW-1:0] m_stage = '0;
  logic [VW-1:0] m_act   = '0;
  logic          m_err   = 1'b0;

  function automatic logic [VW-1:0] pack(int c1, int c2, int c3, int c4);
    return {CW'(c4), CW'(c3), CW'(c2), CW'(c1)};
  endfunction

  function automatic logic bad_word(logic [VW-1:0] v);
    logic b = 1'b0;
    for (int k = 0; k < NO; k++) if (v[k*CW +: CW] > 3'd4) b = 1'b1;
    return b;
  endfunction

  function automatic int preset_in(logic [1:0] s, int k);
    case (s)
      2'b00:   return 0;
      2'b01:   return 1;
      2'b10:   return (k < 2) ? 0 : 2;
      default: return k;
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  // One clock: predict, advance model, compare after the edge.
  task automatic step(string req);
    logic [NO-1:0] e_out, e_en;
    for (int k = 0; k < NO; k++) begin
      int c;
      int src;
      logic en;
      if (preset_mode) begin
        en  = 1'b1;
        src = preset_in(preset_sel, k);
      end else begin
        c   = int'(m_act[k*CW +: CW]);
        en  = (c >= 1) && (c <= 4);
        src = en ? c - 1 : 0;
      end
      e_en[k]  = en;
      e_out[k] = en & din[src];
    end
    @(posedge clk);
    if (rst) begin
      m_stage = '0; m_act = '0; m_err = 1'b0; e_out = '0; e_en = '0;
    end else begin
      if (load) begin
        m_err = bad_word(m_stage);
        m_act = m_stage;
      end
      if (stage_we) m_stage = stage_data;
    end
    @(negedge clk);
    chk(req, "dout", 32'(dout), 32'(e_out));
    chk(req, "dout_en", 32'(dout_en), 32'(e_en));
    chk(req, "cfg_err", 32'(cfg_err), 32'(m_err));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    rst = 1'b1; stage_we = 1'b0; stage_data = '0; load = 1'b0;
    preset_mode = 1'b0; preset_sel = 2'b00; din = '0;
    @(negedge clk);
    step("R9"); step("R9");
    rst = 1'b0;
    din = 4'hF;
    step("R9");

    // R3: staged writes do not reach the outputs
    stage_we = 1'b1; stage_data = pack(1, 2, 3, 4);
    step("R3");
    stage_we = 1'b0;
    for (int i = 0; i < 4; i++) begin din = 4'(i * 5 + 3); step("R3"); end

    // R4: one load, all outputs switch together
    load = 1'b1; din = 4'b1010; step("R4");
    load = 1'b0; din = 4'b0110; step("R4");
    din = 4'b1001; step("R10");
    din = 4'b0101; step("R10");

    // R5: load held high tracks each staged word
    load = 1'b1; stage_we = 1'b1;
    for (int i = 0; i < 4; i++) begin
      stage_data = pack(4 - i, ((i + 1) % 4) + 1, i + 1, 4);
      din = 4'(i * 3 + 1);
      step("R5");
    end
    load = 1'b0; stage_we = 1'b0;
    step("R5"); step("R5");

    // R1: off codes mixed with routed codes
    stage_we = 1'b1; stage_data = pack(0, 4, 0, 1); step("R1");
    stage_we = 1'b0; load = 1'b1; step("R1");
    load = 1'b0;
    for (int i = 0; i < 4; i++) begin din = 4'(1 << i); step("R1"); end

    // R2: invalid codes flagged, outputs kept off, cleared by a valid load
    stage_we = 1'b1; stage_data = pack(5, 1, 7, 6); step("R2");
    stage_we = 1'b0; load = 1'b1; step("R2");
    load = 1'b0; din = 4'hF; step("R2"); step("R2");
    stage_we = 1'b1; stage_data = pack(2, 3, 4, 1); step("R2");
    stage_we = 1'b0; load = 1'b1; step("R2");
    load = 1'b0; step("R2");

    // R6 / R7: presets with several data patterns
    preset_mode = 1'b1;
    for (int s = 0; s < 4; s++) begin
      preset_sel = 2'(s);
      for (int d = 0; d < 4; d++) begin
        din = 4'(d * 7 + s + 1);
        if (s < 2) step("R6"); else step("R7");
      end
    end

    // R8: select ignored with mode low
    preset_mode = 1'b0;
    for (int s = 0; s < 4; s++) begin
      preset_sel = 2'(s); din = 4'(s * 4 + 9);
      step("R8");
    end

    // Random mix
    for (int i = 0; i < 600; i++) begin
      stage_we    = ($urandom % 3) == 0;
      stage_data  = VW'($urandom);
      if (($urandom % 4) != 0) begin
        for (int k = 0; k < NO; k++) stage_data[k*CW +: CW] = CW'($urandom % 5);
      end
      load        = ($urandom % 4) == 0;
      preset_mode = ($urandom % 5) == 0;
      preset_sel  = 2'($urandom);
      din         = 4'($urandom);
      rst         = ($urandom % 97) == 0;
      step("R4");
    end
    rst = 1'b0;

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule